// File: doc/BRIEF.md
# Adaptive Cache Line Size Controller

This block keeps the adaptation metadata for a direct-mapped data cache whose storage is built from 8-byte physical lines. Aligned groups of physical lines form virtual lines whose size can differ from line to line and can change at runtime. The controller sees two kinds of events from the cache: hits and miss fills. From them it keeps, for every physical line, a valid flag, the current virtual size code, a 2-bit saturating usage counter, a dirty flag and an adjacency flag. Every physical line of a virtual line carries a copy of that line's size code, so a lookup at any index finds the size without help from the adaptation logic.

A miss fill brings in a line and may displace one resident line or several. The controller walks the displaced lines one per cycle and reports a recommended next size for each, together with a write-back flag. The next size is chosen from the spatial locality the line showed while it was resident. A mode input sets how a decrease request and an increase request are ranked against each other. Lines fetched for the first time can take their size from a software-written initial-size value.

Size codes are 0..5 for 8, 16, 32, 64, 128 and 256 bytes. A line of code k covers 2^k physical lines whose indices are aligned to 2^k. Its neighbour is the line of the same code at base XOR 2^k. The lower half of a line is its first 2^(k-1) physical lines and the upper half is the rest.

Top module: `lsz_ctrl`

## Requirements
- R1: After reset, busy_o and res_valid_o are 0 and no line is resident, so a fill into an empty region produces no result.
- R2: A hit event (ev_fill_i=0) to a resident index increments that physical line's 2-bit usage counter, which saturates at 3. With ev_write_i=1 it also marks the line dirty. A hit never raises busy_o.
- R3: When a fill installs a line of code k and the neighbour line is resident with the same code k, both lines get their adjacency flag set.
- R4: A line of code 1 or more whose lower half or upper half has only zero usage counters makes a decrease request. When its neighbour is resident with the same code, that neighbour's adjacency flag is cleared.
- R5: A line below code 5 makes an increase request when three things hold: its adjacency flag is set, its neighbour is not resident with the same code, and strictly more than half of its physical lines have usage 1 or less.
- R6: A fill event (ev_fill_i=1) sets busy_o from the next cycle until it completes. If the incoming code is larger than the code resident at the index (an empty index counts as code 0), each resident line inside the incoming region is reported in ascending base order. Its res_wb_o is 1 when the line was dirty or its next size differs from its current size.
- R7: Otherwise exactly the resident line containing the index is reported, if one exists, and res_wb_o equals its dirty flag alone.
- R8: In mode 0 (traffic), a decrease request wins over an increase request.
- R9: In mode 1 (miss rate), an increase request wins over a decrease request.
- R10: In mode 2 or 3 (balanced), a change is applied only on the second consecutive request in the same direction for that slot. A request in the opposite direction replaces the pending direction without a change, and a conflict or the absence of a request leaves the pending state alone.
- R11: A reported next size differs from the current size by at most one code and stays within 0..5.
- R12: A fill with ev_use_init_i=1 installs the line with code init_size_i and ignores ev_size_i.
- R13: Events presented while busy_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 traffic, 1 miss rate, 2/3 balanced |
| init_size_i | input | 3 | Software-written initial size code |
| ev_valid_i | input | 1 | Event strobe |
| ev_fill_i | input | 1 | 1 miss fill, 0 hit |
| ev_index_i | input | IDX_W | Physical line index of the event |
| ev_size_i | input | 3 | Size code of the incoming line |
| ev_use_init_i | input | 1 | Take the fill size from init_size_i |
| ev_write_i | input | 1 | Hit is a store |
| busy_o | output | 1 | Fill in progress, events ignored |
| res_valid_o | output | 1 | Result for one displaced line |
| res_base_o | output | IDX_W | Base index of the displaced line |
| res_cur_size_o | output | 3 | Its size code while resident |
| res_next_size_o | output | 3 | Recommended next size code |
| res_wb_o | output | 1 | Write-back request |

## Verification
No stored flag or counter reaches the ports while its line is resident. A corrupted usage counter, adjacency flag, dirty flag or pending direction therefore shows up only when that line is displaced, as a wrong next size or write-back flag in the result emitted one cycle after the scan reaches the line. Each scenario builds a specific history and then forces the replacement that exposes it. Wrong fill bookkeeping shows up instead as a result that is missing, extra or out of order.

// File: rtl/lsz_pkg.sv
package lsz_pkg;
  localparam int SZ_W = 3;

  typedef enum logic [1:0] {
    MODE_TRAFFIC = 2'd0,
    MODE_MISS    = 2'd1,
    MODE_BAL     = 2'd2,
    MODE_BAL_ALT = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_INC  = 2'd1,
    PEND_DEC  = 2'd2
  } pend_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCAN    = 2'd1,
    ST_INSTALL = 2'd2
  } state_t;
endpackage

// File: rtl/lsz_line_eval.sv
module lsz_line_eval
  import lsz_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int MAX_CODE = 5,
  localparam int NL      = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]         base_i,
  input  logic [SZ_W-1:0]          code_i,
  input  logic [NL-1:0]            valid_i,
  input  logic [NL-1:0][SZ_W-1:0]  size_i,
  input  logic [NL-1:0][1:0]       usage_i,
  input  logic [NL-1:0]            dirty_i,
  input  logic [NL-1:0]            adj_i,
  output logic                     dec_o,
  output logic                     inc_o,
  output logic                     dirty_o,
  output logic [IDX_W-1:0]         bud_o,
  output logic                     bud_res_o
);
  logic [IDX_W-1:0] mask;
  logic [NL-1:0]    in_line;
  logic [NL-1:0]    hi_half;
  logic [NL-1:0]    used;
  logic [NL-1:0]    low;

  assign mask = IDX_W'((1 << int'(code_i)) - 1);

  for (genvar g = 0; g < NL; g++) begin : g_entry
    assign in_line[g] = ((IDX_W'(g) & ~mask) == base_i);
    assign hi_half[g] = (code_i != '0) &&
                        (((g >> (int'(code_i) - 1)) & 1) == 1);
    assign used[g]    = (usage_i[g] != 2'd0);
    assign low[g]     = (usage_i[g] <= 2'd1);
  end

  logic lo_used, hi_used, majority_low;
  int   low_cnt, span;

  always_comb begin
    lo_used      = |(in_line & ~hi_half & used);
    hi_used      = |(in_line &  hi_half & used);
    low_cnt      = $countones(in_line & low);
    span         = 1 << int'(code_i);
    majority_low = (low_cnt * 2) > span;
    dirty_o      = |(in_line & dirty_i);
    if (int'(code_i) < IDX_W) begin
      bud_o     = base_i ^ IDX_W'(1 << int'(code_i));
      bud_res_o = valid_i[bud_o] && (size_i[bud_o] == code_i);
    end else begin
      bud_o     = base_i;
      bud_res_o = 1'b0;
    end
    dec_o = (code_i != '0) && (!lo_used || !hi_used);
    inc_o = (int'(code_i) < MAX_CODE) && adj_i[base_i] && !bud_res_o &&
            majority_low;
  end
endmodule

// File: rtl/lsz_policy.sv
module lsz_policy
  import lsz_pkg::*;
#(
  parameter int MAX_CODE = 5
) (
  input  logic [1:0]      mode_i,
  input  logic            dec_i,
  input  logic            inc_i,
  input  logic [SZ_W-1:0] cur_i,
  input  pend_t           pend_i,
  output logic [SZ_W-1:0] next_o,
  output pend_t           pend_o
);
  logic  [SZ_W-1:0] up, down;
  pend_t dir;

  always_comb begin
    up   = (int'(cur_i) < MAX_CODE) ? cur_i + SZ_W'(1) : cur_i;
    down = (cur_i != '0) ? cur_i - SZ_W'(1) : cur_i;
    if (dec_i && !inc_i)      dir = PEND_DEC;
    else if (inc_i && !dec_i) dir = PEND_INC;
    else                      dir = PEND_NONE;

    next_o = cur_i;
    pend_o = PEND_NONE;
    case (mode_i)
      MODE_TRAFFIC: begin
        if (dec_i)      next_o = down;
        else if (inc_i) next_o = up;
      end
      MODE_MISS: begin
        if (inc_i)      next_o = up;
        else if (dec_i) next_o = down;
      end
      default: begin
        if (dir == PEND_NONE) begin
          pend_o = pend_i;
        end else if (pend_i == dir) begin
          next_o = (dir == PEND_INC) ? up : down;
          pend_o = PEND_NONE;
        end else begin
          pend_o = dir;
        end
      end
    endcase
  end
endmodule

// File: rtl/lsz_ctrl.sv
module lsz_ctrl
  import lsz_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int MAX_CODE = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       init_size_i,
  input  logic             ev_valid_i,
  input  logic             ev_fill_i,
  input  logic [IDX_W-1:0] ev_index_i,
  input  logic [2:0]       ev_size_i,
  input  logic             ev_use_init_i,
  input  logic             ev_write_i,
  output logic             busy_o,
  output logic             res_valid_o,
  output logic [IDX_W-1:0] res_base_o,
  output logic [2:0]       res_cur_size_o,
  output logic [2:0]       res_next_size_o,
  output logic             res_wb_o
);
  localparam int NLINES = 1 << IDX_W;
  localparam int PTR_W  = IDX_W + 1;

  function automatic logic [IDX_W-1:0] low_mask(input logic [SZ_W-1:0] c);
    return IDX_W'((1 << int'(c)) - 1);
  endfunction

  function automatic logic [PTR_W-1:0] span_of(input logic [SZ_W-1:0] c);
    return PTR_W'(1 << int'(c));
  endfunction

  // per physical line metadata
  logic [NLINES-1:0]            valid_q, dirty_q, adj_q;
  logic [NLINES-1:0][SZ_W-1:0]  size_q;
  logic [NLINES-1:0][1:0]       usage_q;
  pend_t                        pend_q [NLINES];

  state_t           state_q;
  logic [PTR_W-1:0] ptr_q, lo_q, hi_q;
  logic [IDX_W-1:0] in_base_q;
  logic [SZ_W-1:0]  in_code_q;
  logic             multi_q;

  assign busy_o = (state_q != ST_IDLE);

  // fill decode
  logic [SZ_W-1:0]  fill_code, old_code;
  logic [IDX_W-1:0] fill_base, old_base;
  logic             fill_multi;
  logic [PTR_W-1:0] fill_lo, fill_hi;

  always_comb begin
    fill_code = ev_use_init_i ? init_size_i : ev_size_i;
    if (int'(fill_code) > MAX_CODE) fill_code = SZ_W'(MAX_CODE);
    fill_base  = ev_index_i & ~low_mask(fill_code);
    old_code   = valid_q[ev_index_i] ? size_q[ev_index_i] : '0;
    old_base   = ev_index_i & ~low_mask(old_code);
    fill_multi = (fill_code > old_code);
    if (fill_multi) begin
      fill_lo = {1'b0, fill_base};
      fill_hi = {1'b0, fill_base} + span_of(fill_code);
    end else begin
      fill_lo = {1'b0, old_base};
      fill_hi = {1'b0, old_base} + span_of(old_code);
    end
  end

  // scan evaluation of the line at the pointer
  logic [IDX_W-1:0] cur_idx;
  logic [SZ_W-1:0]  cur_code;
  logic             ln_dec, ln_inc, ln_dirty, ln_bud_res;
  logic [IDX_W-1:0] ln_bud;
  logic [SZ_W-1:0]  pol_next;
  pend_t            pol_pend;

  assign cur_idx  = ptr_q[IDX_W-1:0];
  assign cur_code = size_q[cur_idx];

  lsz_line_eval #(.IDX_W(IDX_W), .MAX_CODE(MAX_CODE)) i_eval (
    .base_i    (cur_idx),
    .code_i    (cur_code),
    .valid_i   (valid_q),
    .size_i    (size_q),
    .usage_i   (usage_q),
    .dirty_i   (dirty_q),
    .adj_i     (adj_q),
    .dec_o     (ln_dec),
    .inc_o     (ln_inc),
    .dirty_o   (ln_dirty),
    .bud_o     (ln_bud),
    .bud_res_o (ln_bud_res)
  );

  lsz_policy #(.MAX_CODE(MAX_CODE)) i_policy (
    .mode_i (mode_i),
    .dec_i  (ln_dec),
    .inc_i  (ln_inc),
    .cur_i  (cur_code),
    .pend_i (pend_q[cur_idx]),
    .next_o (pol_next),
    .pend_o (pol_pend)
  );

  // neighbour of the incoming line, checked at install
  logic [IDX_W-1:0] in_bud;
  logic             in_bud_match;

  always_comb begin
    if (int'(in_code_q) < IDX_W) begin
      in_bud       = in_base_q ^ IDX_W'(1 << int'(in_code_q));
      in_bud_match = (({1'b0, in_bud} < lo_q) || ({1'b0, in_bud} >= hi_q)) &&
                     valid_q[in_bud] && (size_q[in_bud] == in_code_q);
    end else begin
      in_bud       = in_base_q;
      in_bud_match = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q         <= '0;
      dirty_q         <= '0;
      adj_q           <= '0;
      size_q          <= '0;
      usage_q         <= '0;
      for (int j = 0; j < NLINES; j++) pend_q[j] <= PEND_NONE;
      state_q         <= ST_IDLE;
      ptr_q           <= '0;
      lo_q            <= '0;
      hi_q            <= '0;
      in_base_q       <= '0;
      in_code_q       <= '0;
      multi_q         <= 1'b0;
      res_valid_o     <= 1'b0;
      res_base_o      <= '0;
      res_cur_size_o  <= '0;
      res_next_size_o <= '0;
      res_wb_o        <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ev_valid_i && ev_fill_i) begin
            ptr_q     <= fill_lo;
            lo_q      <= fill_lo;
            hi_q      <= fill_hi;
            in_base_q <= fill_base;
            in_code_q <= fill_code;
            multi_q   <= fill_multi;
            state_q   <= ST_SCAN;
          end else if (ev_valid_i && valid_q[ev_index_i]) begin
            if (usage_q[ev_index_i] != 2'd3)
              usage_q[ev_index_i] <= usage_q[ev_index_i] + 2'd1;
            if (ev_write_i) dirty_q[ev_index_i] <= 1'b1;
          end
        end
        ST_SCAN: begin
          if (ptr_q >= hi_q) begin
            state_q <= ST_INSTALL;
          end else if (valid_q[cur_idx]) begin
            res_valid_o     <= 1'b1;
            res_base_o      <= cur_idx;
            res_cur_size_o  <= cur_code;
            res_next_size_o <= pol_next;
            res_wb_o        <= ln_dirty || (multi_q && (pol_next != cur_code));
            pend_q[cur_idx] <= pol_pend;
            if (ln_dec && ln_bud_res) adj_q[ln_bud] <= 1'b0;
            ptr_q <= ptr_q + span_of(cur_code);
          end else begin
            ptr_q <= ptr_q + PTR_W'(1);
          end
        end
        default: begin
          for (int j = 0; j < NLINES; j++) begin
            if ((PTR_W'(j) >= lo_q) && (PTR_W'(j) < hi_q)) begin
              valid_q[j] <= 1'b0;
              dirty_q[j] <= 1'b0;
              usage_q[j] <= 2'd0;
              adj_q[j]   <= 1'b0;
            end
            if ((IDX_W'(j) & ~low_mask(in_code_q)) == in_base_q) begin
              valid_q[j] <= 1'b1;
              size_q[j]  <= in_code_q;
            end
          end
          adj_q[in_base_q] <= in_bud_match;
          if (in_bud_match) adj_q[in_bud] <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsz_ctrl_chk.sv
module lsz_ctrl_chk #(
  parameter int IDX_W    = 6,
  parameter int MAX_CODE = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic [2:0]       init_size_i,
  input logic             ev_valid_i,
  input logic             ev_fill_i,
  input logic [IDX_W-1:0] ev_index_i,
  input logic [2:0]       ev_size_i,
  input logic             ev_use_init_i,
  input logic             ev_write_i,
  input logic             busy_o,
  input logic             res_valid_o,
  input logic [IDX_W-1:0] res_base_o,
  input logic [2:0]       res_cur_size_o,
  input logic [2:0]       res_next_size_o,
  input logic             res_wb_o
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy_o && !res_valid_o));

  a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && ev_valid_i && !ev_fill_i) |=> !busy_o);

  a_r6_fill_goes_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && ev_valid_i && ev_fill_i) |=> busy_o);

  a_r6_result_only_busy: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> busy_o);

  a_r11_one_step: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> ((res_next_size_o == res_cur_size_o) ||
                     (int'(res_next_size_o) == int'(res_cur_size_o) + 1) ||
                     (int'(res_next_size_o) + 1 == int'(res_cur_size_o))));

  a_r11_cap: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (int'(res_next_size_o) <= MAX_CODE));
endmodule

bind lsz_ctrl lsz_ctrl_chk #(.IDX_W(IDX_W), .MAX_CODE(MAX_CODE)) i_lsz_chk (.*);

// File: tb/test_lsz_ctrl.sv
module test_lsz_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode_i = 2'd0;
  logic [2:0]       init_size_i = 3'd0;
  logic             ev_valid_i = 1'b0;
  logic             ev_fill_i = 1'b0;
  logic [IDX_W-1:0] ev_index_i = '0;
  logic [2:0]       ev_size_i = 3'd0;
  logic             ev_use_init_i = 1'b0;
  logic             ev_write_i = 1'b0;
  logic             busy_o, res_valid_o, res_wb_o;
  logic [IDX_W-1:0] res_base_o;
  logic [2:0]       res_cur_size_o, res_next_size_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lsz_ctrl #(.IDX_W(IDX_W), .MAX_CODE(5)) i_lsz_ctrl (.*);

  typedef struct {
    int    base;
    int    cur;
    int    nxt;
    int    wb;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  task automatic expect_res(int b, int c, int n, int w, string tag);
    exp_t e;
    e.base = b; e.cur = c; e.nxt = n; e.wb = w; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares each produced result with the queue head
  always @(negedge clk) begin
    if (!rst && res_valid_o) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected result base=%0d cur=%0d next=%0d wb=%0d (expected none)",
                 res_base_o, res_cur_size_o, res_next_size_o, res_wb_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (int'(res_base_o) != e.base || int'(res_cur_size_o) != e.cur ||
            int'(res_next_size_o) != e.nxt || int'(res_wb_o) != e.wb) begin
          errors++;
          $display("FAIL %s: base=%0d cur=%0d next=%0d wb=%0d expected base=%0d cur=%0d next=%0d wb=%0d",
                   e.tag, res_base_o, res_cur_size_o, res_next_size_o, res_wb_o,
                   e.base, e.cur, e.nxt, e.wb);
        end
      end
    end
  end

  task automatic fill(int idx, int code, bit use_init);
    @(negedge clk);
    ev_valid_i = 1'b1; ev_fill_i = 1'b1; ev_index_i = IDX_W'(idx);
    ev_size_i = 3'(code); ev_use_init_i = use_init; ev_write_i = 1'b0;
    @(negedge clk);
    ev_valid_i = 1'b0;
    while (busy_o) @(negedge clk);
  endtask

  task automatic hit(int idx, bit wr);
    @(negedge clk);
    ev_valid_i = 1'b1; ev_fill_i = 1'b0; ev_index_i = IDX_W'(idx);
    ev_write_i = wr; ev_use_init_i = 1'b0;
    @(negedge clk);
    ev_valid_i = 1'b0; ev_write_i = 1'b0;
  endtask

  task automatic set_mode(int m);
    @(negedge clk);
    mode_i = 2'(m);
  endtask

  task automatic check_bit(bit act, bit exp_v, string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_bit(busy_o, 1'b0, "R1 busy after reset");
    check_bit(res_valid_o, 1'b0, "R1 result after reset");

    // traffic mode, decrease and neighbour flag clearing
    set_mode(0);
    init_size_i = 3'd1;
    fill(0, 1, 1'b0);               // R1: empty region, no result
    fill(2, 3, 1'b1);               // R12: init code 1 used, R3 adjacency with line 0
    hit(0, 1'b0);
    expect_res(0, 1, 0, 0, "R4 R7 R8 upper half unused shrinks");
    fill(0, 0, 1'b0);
    hit(2, 1'b0); hit(3, 1'b0);
    expect_res(2, 1, 1, 0, "R4 R12 neighbour flag cleared, init size");
    fill(2, 1, 1'b0);

    // miss-rate mode, increase and multi displacement
    set_mode(1);
    fill(4, 1, 1'b0); fill(6, 1, 1'b0);
    hit(4, 1'b1); hit(5, 1'b0); hit(6, 1'b0); hit(7, 1'b0);
    expect_res(6, 1, 1, 0, "R5 neighbour resident blocks growth");
    fill(6, 0, 1'b0);
    expect_res(4, 1, 2, 1, "R5 R6 grow, dirty write-back");
    expect_res(6, 0, 0, 0, "R6 R11 second displaced line, floor at 8B");
    fill(4, 2, 1'b0);

    // saturating usage counter
    fill(48, 1, 1'b0); fill(50, 1, 1'b0);
    for (int i = 0; i < 5; i++) hit(48, 1'b0);
    hit(49, 1'b0); hit(50, 1'b0); hit(51, 1'b0);
    expect_res(50, 1, 1, 0, "R2 setup neighbour");
    fill(50, 0, 1'b0);
    expect_res(48, 1, 1, 0, "R2 usage saturates at 3");
    fill(48, 1, 1'b0);

    // traffic mode: size change forces write-back on multi displacement
    set_mode(0);
    fill(8, 1, 1'b0);
    hit(8, 1'b0);
    expect_res(8, 1, 0, 1, "R6 size change write-back");
    fill(8, 2, 1'b0);

    // conflict in traffic mode
    fill(16, 1, 1'b0); fill(18, 1, 1'b0);
    hit(16, 1'b0); hit(18, 1'b0); hit(19, 1'b0);
    expect_res(18, 1, 1, 0, "R8 setup neighbour");
    fill(18, 0, 1'b0);
    expect_res(16, 1, 0, 0, "R8 decrease wins");
    fill(16, 1, 1'b0);

    // conflict in miss-rate mode
    set_mode(1);
    fill(20, 1, 1'b0); fill(22, 1, 1'b0);
    hit(20, 1'b0); hit(22, 1'b0); hit(23, 1'b0);
    expect_res(22, 1, 1, 0, "R9 setup neighbour");
    fill(22, 0, 1'b0);
    expect_res(20, 1, 2, 0, "R9 increase wins");
    fill(20, 1, 1'b0);

    // events while busy are ignored
    set_mode(0);
    fill(40, 1, 1'b0);
    hit(40, 1'b0);
    @(negedge clk);
    ev_valid_i = 1'b1; ev_fill_i = 1'b1; ev_index_i = IDX_W'(42);
    ev_size_i = 3'd0; ev_use_init_i = 1'b0;
    @(negedge clk);
    check_bit(busy_o, 1'b1, "R6 busy after fill");
    ev_fill_i = 1'b0; ev_index_i = IDX_W'(41);   // hit while busy
    @(negedge clk);
    ev_valid_i = 1'b0;
    while (busy_o) @(negedge clk);
    expect_res(40, 1, 0, 0, "R13 hit during busy ignored");
    fill(40, 1, 1'b0);

    // balanced mode: two consecutive decreases
    set_mode(2);
    fill(24, 2, 1'b0);
    hit(24, 1'b0);
    expect_res(24, 2, 2, 0, "R10 first decrease held");
    fill(24, 2, 1'b0);
    hit(24, 1'b0);
    expect_res(24, 2, 1, 0, "R10 second decrease applied");
    fill(24, 2, 1'b0);

    // balanced mode: reversal
    fill(32, 1, 1'b0);
    hit(32, 1'b0);
    expect_res(32, 1, 1, 0, "R10 decrease pending");
    fill(32, 1, 1'b0);
    fill(34, 1, 1'b0);
    hit(32, 1'b0); hit(33, 1'b0); hit(34, 1'b0); hit(35, 1'b0);
    expect_res(34, 1, 1, 0, "R10 setup neighbour");
    fill(34, 0, 1'b0);
    expect_res(32, 1, 1, 0, "R10 reversal not applied");
    fill(32, 1, 1'b0);
    expect_res(34, 0, 0, 0, "R6 regrow neighbour");
    fill(34, 1, 1'b0);
    hit(32, 1'b0); hit(33, 1'b0); hit(34, 1'b0); hit(35, 1'b0);
    expect_res(34, 1, 1, 0, "R10 setup neighbour again");
    fill(34, 0, 1'b0);
    expect_res(32, 1, 2, 0, "R10 second increase applied");
    fill(32, 1, 1'b0);

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 R7 missing results: actual=0 expected=%0d", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule